// File: doc/BRIEF.md
# ROM Column Observation Selector

This block picks which bit lines of a read-only memory are observed by the signature register during a built-in self-test sweep. It holds a small linear feedback register (the diffractor) that steps each time the word (column) address advances. The diffractor state is XORed with the current partition number to form a column index, so one partition group visits a fixed, scrambled set of columns across the words of a row.

Several columns are observed at once. The word is split into equal slices, and each slice has its own one-of-many decoder. Each decoder is fed through a fixed XOR network (a phase shifter) that reproduces the diffractor sequence at a set offset. In each run, the first word position uses a zero contribution, which covers the one state the register can never reach. A trellis mode seeds the diffractor with the group number plus one. This breaks the fixed pairing with a row selector that uses the same polynomial. A disable input opens the whole mask so that all columns are observed.

Top module: `col_observe_sel`

## Requirements
- R1: During and after reset, and before any run start, the block is at the first word position of a run whose diffractor state is 1. With col_disable low, each slice selects index `partition`.
- R2: While col_disable is high, every bit of mask is 1.
- R3: While col_disable is low, each slice `mask[i*2^N +: 2^N]` has exactly one bit set. That bit is the slice's column index.
- R4: After a run_start, the first word position uses a zero contribution, so every slice selects index `partition`.
- R5: At word position k ≥ 1 of a run, the diffractor holds the state reached from the seed after k-1 steps. The update rule is next = {s[N-2:0], ^(s & TAPS)}. With the defaults (N=3, TAPS=3'b110) the trajectory from 1 is 1,2,5,3,7,6,4 and it repeats with period 7.
- R6: Slice i selects `partition XOR PS_i(state)`, where PS_i gives the state that lies OFS_i steps further along the trajectory. The default offsets 6, 5, 2 for slices 0, 1, 2 turn state 1 into 4, 6 and 5.
- R7: At run_start the seed is `group` when trellis_en is low, and `group + 1` (modulo 2^N) when trellis_en is high.
- R8: A seed that works out to zero is loaded as 1.
- R9: run_start takes priority over col_inc. When neither is high, the selection does not change.
- R10: Over the 2^N word positions of one run, each slice selects every one of its 2^N indices exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_start | input | 1 | Loads the seed and returns to the first word position |
| col_inc | input | 1 | Word address has incremented; advances one position |
| partition | input | N | Current partition number |
| group | input | N | Current partition group number |
| trellis_en | input | 1 | Seed with group + 1 for combined row/column mode |
| col_disable | input | 1 | Forces the mask to all ones |
| mask | output | T*2^N | Column observe mask, slice i at bits i*2^N upward |

## Verification
The assertions assume that run_start and col_inc are single-cycle strobes sampled at the clock edge. They also assume that partition is held steady while a position is being compared. The hold check therefore applies only when partition and col_disable are unchanged across the cycle. The bench changes partition, group and trellis_en only together with a run_start pulse, and it raises each strobe for exactly one clock. This keeps every compared position within these assumptions.

// File: rtl/col_observe_sel.sv
module col_observe_sel #(
  parameter int N = 3,
  parameter int T = 3,
  parameter logic [N-1:0] TAPS = 3'b110,
  parameter logic [T*16-1:0] PS_OFS = {16'd2, 16'd5, 16'd6}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_start,
  input  logic             col_inc,
  input  logic [N-1:0]     partition,
  input  logic [N-1:0]     group,
  input  logic             trellis_en,
  input  logic             col_disable,
  output logic [T*(1<<N)-1:0] mask
);
  localparam int S = 1 << N;

  function automatic logic [N-1:0] lfsr_step(input logic [N-1:0] v);
    return {v[N-2:0], ^(v & TAPS)};
  endfunction

  function automatic logic [N-1:0] lfsr_jump(input logic [N-1:0] v, input int cnt);
    logic [N-1:0] r;
    r = v;
    for (int j = 0; j < S; j++)
      if (j < cnt) r = lfsr_step(r);
    return r;
  endfunction

  logic [N-1:0] diff_q;
  logic         first_q;
  logic [N-1:0] seed_raw;
  logic [N-1:0] seed;

  assign seed_raw = trellis_en ? N'(group + N'(1)) : group;
  assign seed     = (seed_raw == '0) ? N'(1) : seed_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      diff_q  <= N'(1);
      first_q <= 1'b1;
    end else if (run_start) begin
      diff_q  <= seed;
      first_q <= 1'b1;
    end else if (col_inc) begin
      if (first_q) first_q <= 1'b0;
      else         diff_q  <= lfsr_step(diff_q);
    end
  end

  for (genvar i = 0; i < T; i++) begin : g_slice
    localparam int OFS = int'(PS_OFS[i*16 +: 16]);
    logic [N-1:0] ps_out;
    logic [N-1:0] idx;
    assign ps_out = lfsr_jump(diff_q, OFS);
    assign idx    = partition ^ (first_q ? '0 : ps_out);
    assign mask[i*S +: S] = col_disable ? {S{1'b1}} : (S'(1) << idx);
  end
endmodule

// File: rtl/col_observe_sel_chk.sv
module col_observe_sel_chk #(
  parameter int N = 3,
  parameter int T = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 run_start,
  input logic                 col_inc,
  input logic [N-1:0]         partition,
  input logic                 col_disable,
  input logic [T*(1<<N)-1:0]  mask
);
  localparam int S = 1 << N;

  // R2
  all_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_disable |-> (mask == {T*S{1'b1}}));

  for (genvar i = 0; i < T; i++) begin : g_chk
    // R3
    slice_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !col_disable |-> ($countones(mask[i*S +: S]) == 1));
  end

  // R4
  first_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> (col_disable || (partition != $past(partition)) || mask[partition]));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!run_start && !col_inc) && $stable(partition) && !col_disable && !$past(col_disable))
      |-> $stable(mask));
endmodule

bind col_observe_sel col_observe_sel_chk #(.N(N), .T(T)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_start(run_start), .col_inc(col_inc),
  .partition(partition), .col_disable(col_disable), .mask(mask)
);

// File: tb/sim_col_observe_sel.sv
module sim_col_observe_sel;
  localparam int NV = 6;
  // partition, group, trellis, positions, expected seed
  localparam int VEC [NV][5] = '{
    '{2, 3, 0, 9, 3},
    '{5, 1, 0, 8, 1},
    '{0, 6, 1, 8, 7},
    '{7, 4, 1, 5, 5},
    '{3, 7, 1, 8, 1},
    '{1, 0, 0, 4, 1}
  };
  localparam int TR [7] = '{1, 2, 5, 3, 7, 6, 4};
  localparam int OF [3] = '{6, 5, 2};

  logic clk = 0, rst_n = 0, run_start = 0, col_inc = 0, trellis_en = 0, col_disable = 0;
  logic [2:0] partition = 3'd3, group = 3'd0;
  logic [23:0] mask;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  col_observe_sel u0 (.clk(clk), .rst_n(rst_n), .run_start(run_start), .col_inc(col_inc),
    .partition(partition), .group(group), .trellis_en(trellis_en),
    .col_disable(col_disable), .mask(mask));

  function automatic logic [23:0] model(int part, int seed, int k);
    logic [23:0] m = '0;
    int p = 0;
    for (int j = 0; j < 7; j++) if (TR[j] == seed) p = j;
    for (int i = 0; i < 3; i++) begin
      int c = (k == 0) ? 0 : TR[(p + k - 1 + OF[i]) % 7];
      m[i*8 + (part ^ c)] = 1'b1;
    end
    return m;
  endfunction

  task automatic tick;
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic check(logic [23:0] act, logic [23:0] exp, string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: mask=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start_run(int part, int grp, int trl);
    partition = 3'(part); group = 3'(grp); trellis_en = trl[0];
    run_start = 1; tick; run_start = 0;
  endtask

  task automatic step;
    col_inc = 1; tick; col_inc = 0;
  endtask

  initial begin
    logic [23:0] acc;
    repeat (3) tick;
    // R1 reset state
    check(mask, 24'h080808, "R1 during reset");
    rst_n = 1; tick;
    check(mask, 24'h080808, "R1 after reset");

    // R4 R5 R7 R8 table sweep
    foreach (VEC[v]) begin
      start_run(VEC[v][0], VEC[v][1], VEC[v][2]);
      for (int k = 0; k < VEC[v][3]; k++) begin
        check(mask, model(VEC[v][0], VEC[v][4], k), k == 0 ? "R4" : "R5 R7 R8");
        step;
      end
    end

    // R6 phase shifter starting values from state 1
    start_run(0, 1, 0); step;
    check(mask, 24'h204010, "R6");

    // R9 hold without strobes
    start_run(4, 5, 0); step; step;
    repeat (3) tick;
    check(mask, model(4, 5, 2), "R9 hold");

    // R9 run_start wins over col_inc
    partition = 3'd6; group = 3'd2; trellis_en = 0;
    run_start = 1; col_inc = 1; tick; run_start = 0; col_inc = 0;
    check(mask, 24'h404040, "R9 priority");

    // R2 disable forces all ones, selection resumes after
    col_disable = 1; tick;
    check(mask, 24'hFFFFFF, "R2");
    step;
    check(mask, 24'hFFFFFF, "R2 during step");
    col_disable = 0; #1;
    check(mask, model(6, 2, 1), "R2 release");

    // R3 R10 full coverage in one run
    start_run(5, 6, 1);
    acc = '0;
    for (int k = 0; k < 8; k++) begin
      acc |= mask;
      checks++;
      if ($countones(mask) != 3) begin
        fails++;
        $display("FAIL R3: ones=%0d expected=3", $countones(mask));
      end
      step;
    end
    check(acc, 24'hFFFFFF, "R10");
    check(mask, model(5, 7, 8), "R5 wrap");

    // R8 trellis wrap to zero
    start_run(0, 7, 1); step;
    check(mask, model(0, 1, 1), "R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: cycles=200000 expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule